// File: doc/BRIEF.md
# Memory-to-Memory 3x3 Vertical Gradient Filter

This engine filters a greyscale frame of 8-bit pixels that sits in shared memory. Software writes a source byte address and a destination byte address into a small register file, then sets a self-clearing start bit. No separate DMA is involved: the engine is the bus master. It fetches every source pixel once, in raster order, through a request/response read port. It buffers the pixels in a small FIFO, two line memories and a sliding 3x3 window. It then stores one filtered pixel per source pixel through a write port that uses valid/ready and a separate acknowledge pulse.

Each output pixel sits at the centre of its 3x3 neighbourhood. Its value is the weighted bottom row (1,2,1) minus the weighted top row (1,2,1), clamped to 0..255. Neighbours that fall outside the frame take the value of the nearest edge pixel, so the output frame has the same size as the input frame. The frame size defaults to 360 rows by 640 columns. A status register reports completion and idleness.

Top module: `c3f_engine`

## Requirements
- R1: After reset the status register reads idle=1 (bit 2), done=0 (bit 1) and start=0 (bit 0), and neither rd_req_valid nor wr_valid is asserted.
- R2: A write to offset 0x10 sets the source base and a write to offset 0x18 sets the destination base. A read strobe returns the register on s_rd_data one cycle later.
- R3: Writing a 1 to bit 0 of offset 0x00 while idle starts a frame. Read requests then go to source base + n for n = 0 .. ROWS*COLS-1, each address once and in increasing order.
- R4: Output pixel (r,c) equals in(r+1,c-1) + 2*in(r+1,c) + in(r+1,c+1) - in(r-1,c-1) - 2*in(r-1,c) - in(r-1,c+1).
- R5: A row or column index outside the frame is clamped to the nearest edge, so border outputs use replicated edge pixels.
- R6: A negative sum gives 0 and a sum above 255 gives 255.
- R7: Output pixel n = r*COLS + c is written to destination base + n. Writes come in raster order, exactly ROWS*COLS of them per frame.
- R8: Read requests that have no response yet never exceed FIFO_DEPTH. With responses withheld, exactly FIFO_DEPTH requests are issued.
- R9: While wr_valid is high and wr_ready is low, wr_valid, wr_addr and wr_data hold steady into the next cycle.
- R10: Status idle reads 0 while a frame runs. Done is raised only after the final write acknowledge, and idle returns to 1 at the same point. Reading the status register clears done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| s_wr_en | input | 1 | Register write strobe |
| s_wr_addr | input | 8 | Register write byte offset |
| s_wr_data | input | 32 | Register write data |
| s_rd_en | input | 1 | Register read strobe |
| s_rd_addr | input | 8 | Register read byte offset |
| s_rd_data | output | 32 | Register read data, one cycle after strobe |
| rd_req_valid | output | 1 | Read request valid |
| rd_req_ready | input | 1 | Memory accepts read request |
| rd_req_addr | output | 32 | Byte address of requested pixel |
| rd_resp_valid | input | 1 | Read response valid, in request order |
| rd_resp_data | input | 8 | Returned pixel |
| wr_valid | output | 1 | Write valid |
| wr_ready | input | 1 | Memory accepts write |
| wr_addr | output | 32 | Byte address of output pixel |
| wr_data | output | 8 | Output pixel |
| wr_ack | input | 1 | One pulse per completed write |

## Verification
Suppose the row or column counters or a line memory slot hold the wrong content. The first affected pixel then reaches the write port with a wrong value or address within a few cycles, usually in the first or last row or column. The scoreboard compares every output, so this is found on that very write. A wrong credit count shows up as extra outstanding read requests, or as a stall, while responses are being withheld. A wrong acknowledge count shows up as done rising before the last acknowledge, or never rising at all.

// File: rtl/c3f_pkg.sv
package c3f_pkg;
  localparam logic [7:0] REG_CTRL = 8'h00;
  localparam logic [7:0] REG_SRC  = 8'h10;
  localparam logic [7:0] REG_DST  = 8'h18;

  typedef struct packed {
    logic [7:0] t;
    logic [7:0] m;
    logic [7:0] b;
  } c3f_col_t;

  // vertical gradient on three columns, clamped to a byte
  function automatic logic [7:0] c3f_kernel(c3f_col_t l, c3f_col_t c, c3f_col_t r);
    logic signed [11:0] acc;
    acc = $signed({4'd0, l.b}) + $signed({3'd0, c.b, 1'b0}) + $signed({4'd0, r.b})
        - $signed({4'd0, l.t}) - $signed({3'd0, c.t, 1'b0}) - $signed({4'd0, r.t});
    if (acc < 12'sd0)        return 8'd0;
    else if (acc > 12'sd255) return 8'hFF;
    else                     return acc[7:0];
  endfunction
endpackage

// File: rtl/c3f_regs.sv
module c3f_regs
  import c3f_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        s_wr_en,
  input  logic [7:0]  s_wr_addr,
  input  logic [31:0] s_wr_data,
  input  logic        s_rd_en,
  input  logic [7:0]  s_rd_addr,
  output logic [31:0] s_rd_data,
  input  logic        busy,
  input  logic        finish,
  output logic        start,
  output logic        done,
  output logic [31:0] src_base,
  output logic [31:0] dst_base
);
  always_ff @(posedge clk) begin
    if (rst) begin
      src_base  <= '0;
      dst_base  <= '0;
      done      <= 1'b0;
      start     <= 1'b0;
      s_rd_data <= '0;
    end else begin
      start <= s_wr_en && (s_wr_addr == REG_CTRL) && s_wr_data[0] && !busy && !start;
      if (s_wr_en && s_wr_addr == REG_SRC) src_base <= s_wr_data;
      if (s_wr_en && s_wr_addr == REG_DST) dst_base <= s_wr_data;
      if (s_rd_en) begin
        case (s_rd_addr)
          REG_CTRL: s_rd_data <= {29'd0, !busy, done, 1'b0};
          REG_SRC:  s_rd_data <= src_base;
          REG_DST:  s_rd_data <= dst_base;
          default:  s_rd_data <= '0;
        endcase
      end
      if (finish)                                done <= 1'b1;
      else if (s_rd_en && s_rd_addr == REG_CTRL) done <= 1'b0;
      else if (start)                            done <= 1'b0;
    end
  end
endmodule

// File: rtl/c3f_fetch.sv
module c3f_fetch #(
  parameter int TOTAL = 230400,
  parameter int DEPTH = 8
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        start,
  input  logic [31:0] base,
  output logic        rd_req_valid,
  input  logic        rd_req_ready,
  output logic [31:0] rd_req_addr,
  input  logic        rd_resp_valid,
  input  logic [7:0]  rd_resp_data,
  input  logic        pop,
  output logic [7:0]  pix,
  output logic        avail
);
  localparam int NW = $clog2(TOTAL + 1);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [NW-1:0] issued;
  logic [CW-1:0] used;   // requested but not yet consumed
  logic [CW-1:0] cnt;    // stored in FIFO
  logic [AW-1:0] wp, rp;
  logic [31:0]   base_q;
  logic [7:0]    fifo [DEPTH];
  logic          req_fire;

  assign rd_req_valid = (issued != NW'(TOTAL)) && (used != CW'(DEPTH));
  assign rd_req_addr  = base_q + 32'(issued);
  assign req_fire     = rd_req_valid && rd_req_ready;
  assign pix          = fifo[rp];
  assign avail        = (cnt != '0);

  always_ff @(posedge clk) begin
    if (rd_resp_valid) fifo[wp] <= rd_resp_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      issued <= NW'(TOTAL);
      used   <= '0;
      cnt    <= '0;
      wp     <= '0;
      rp     <= '0;
      base_q <= '0;
    end else if (start) begin
      issued <= '0;
      used   <= '0;
      cnt    <= '0;
      wp     <= '0;
      rp     <= '0;
      base_q <= base;
    end else begin
      if (req_fire) issued <= issued + NW'(1);
      used <= used + {{(CW-1){1'b0}}, req_fire} - {{(CW-1){1'b0}}, pop};
      cnt  <= cnt + {{(CW-1){1'b0}}, rd_resp_valid} - {{(CW-1){1'b0}}, pop};
      if (rd_resp_valid) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + AW'(1);
      if (pop)           rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + AW'(1);
    end
  end
endmodule

// File: rtl/c3f_window.sv
module c3f_window
  import c3f_pkg::*;
#(
  parameter int ROWS = 360,
  parameter int COLS = 640
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        start,
  input  logic [31:0] dst_base,
  input  logic        avail,
  input  logic [7:0]  pix,
  output logic        pop,
  output logic        wr_valid,
  input  logic        wr_ready,
  output logic [31:0] wr_addr,
  output logic [7:0]  wr_data
);
  localparam int RW = $clog2(ROWS + 1);
  localparam int CW = $clog2(COLS + 1);
  localparam int IW = (COLS > 1) ? $clog2(COLS) : 1;
  localparam int NW = $clog2(ROWS * COLS + 1);
  localparam logic [RW-1:0] KLAST = RW'(ROWS);
  localparam logic [CW-1:0] JLAST = CW'(COLS);

  logic [RW-1:0] k;      // step row: 0..ROWS (ROWS = virtual bottom row)
  logic [CW-1:0] j;      // step column: 0..COLS (COLS = virtual right column)
  logic          run, wv, fire, need_pix, out_take, out_load, xrow, xcol;
  logic [IW-1:0] ja;
  logic [7:0]    lb1 [COLS];  // row k-1
  logic [7:0]    lb2 [COLS];  // row k-2
  logic [7:0]    m1, m2, newp;
  logic [NW-1:0] n;
  logic [31:0]   dst_q;
  c3f_col_t      w_l, w_c, w_r, v;

  assign xrow     = (k == KLAST);
  assign xcol     = (j == JLAST);
  assign ja       = xcol ? '0 : IW'(j);
  assign m1       = lb1[ja];
  assign m2       = lb2[ja];
  assign newp     = xrow ? m1 : pix;
  assign need_pix = !xrow && !xcol;
  assign out_take = !wr_valid || wr_ready;
  assign fire     = run && (!need_pix || avail) && (!wv || out_take);
  assign pop      = fire && need_pix;
  assign out_load = wv && out_take;

  always_comb begin
    if (xcol) v = w_r;
    else begin
      v.b = newp;
      v.m = (k == '0) ? newp : m1;
      v.t = (k <= RW'(1)) ? v.m : m2;
    end
  end

  always_ff @(posedge clk) begin
    if (fire && !xcol) begin
      lb1[ja] <= newp;
      lb2[ja] <= m1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run <= 1'b0; k <= '0; j <= '0; wv <= 1'b0; n <= '0;
      wr_valid <= 1'b0; wr_addr <= '0; wr_data <= '0; dst_q <= '0;
      w_l <= '0; w_c <= '0; w_r <= '0;
    end else if (start) begin
      run <= 1'b1; k <= '0; j <= '0; wv <= 1'b0; n <= '0;
      dst_q <= dst_base;
    end else begin
      if (out_load) begin
        wr_valid <= 1'b1;
        wr_data  <= c3f_kernel(w_l, w_c, w_r);
        wr_addr  <= dst_q + 32'(n);
        n        <= n + NW'(1);
        wv       <= 1'b0;
      end else if (wr_valid && wr_ready) begin
        wr_valid <= 1'b0;
      end
      if (fire) begin
        wv <= (k != '0) && (j != '0);
        if (j == '0) begin
          w_c <= v;
          w_r <= v;
        end else begin
          w_l <= w_c;
          w_c <= w_r;
          w_r <= v;
        end
        if (xcol) begin
          j <= '0;
          if (xrow) run <= 1'b0;
          else      k <= k + RW'(1);
        end else begin
          j <= j + CW'(1);
        end
      end
    end
  end
endmodule

// File: rtl/c3f_engine.sv
module c3f_engine #(
  parameter int ROWS       = 360,
  parameter int COLS       = 640,
  parameter int FIFO_DEPTH = 8
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        s_wr_en,
  input  logic [7:0]  s_wr_addr,
  input  logic [31:0] s_wr_data,
  input  logic        s_rd_en,
  input  logic [7:0]  s_rd_addr,
  output logic [31:0] s_rd_data,
  output logic        rd_req_valid,
  input  logic        rd_req_ready,
  output logic [31:0] rd_req_addr,
  input  logic        rd_resp_valid,
  input  logic [7:0]  rd_resp_data,
  output logic        wr_valid,
  input  logic        wr_ready,
  output logic [31:0] wr_addr,
  output logic [7:0]  wr_data,
  input  logic        wr_ack
);
  localparam int TOTAL = ROWS * COLS;
  localparam int NW    = $clog2(TOTAL + 1);

  logic          busy, finish, start, done_flag, pop, avail;
  logic [31:0]   src_base, dst_base;
  logic [7:0]    pix;
  logic [NW-1:0] acks;

  assign finish = busy && wr_ack && (acks == NW'(TOTAL - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      acks <= '0;
    end else if (start) begin
      busy <= 1'b1;
      acks <= '0;
    end else if (busy && wr_ack) begin
      acks <= acks + NW'(1);
      if (finish) busy <= 1'b0;
    end
  end

  c3f_regs i_regs (
    .clk(clk), .rst(rst),
    .s_wr_en(s_wr_en), .s_wr_addr(s_wr_addr), .s_wr_data(s_wr_data),
    .s_rd_en(s_rd_en), .s_rd_addr(s_rd_addr), .s_rd_data(s_rd_data),
    .busy(busy), .finish(finish), .start(start), .done(done_flag),
    .src_base(src_base), .dst_base(dst_base)
  );

  c3f_fetch #(.TOTAL(TOTAL), .DEPTH(FIFO_DEPTH)) i_fetch (
    .clk(clk), .rst(rst), .start(start), .base(src_base),
    .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready), .rd_req_addr(rd_req_addr),
    .rd_resp_valid(rd_resp_valid), .rd_resp_data(rd_resp_data),
    .pop(pop), .pix(pix), .avail(avail)
  );

  c3f_window #(.ROWS(ROWS), .COLS(COLS)) i_window (
    .clk(clk), .rst(rst), .start(start), .dst_base(dst_base),
    .avail(avail), .pix(pix), .pop(pop),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data)
  );
endmodule

// File: rtl/c3f_checker.sv
module c3f_checker #(
  parameter int DEPTH = 8
) (
  input logic        clk,
  input logic        rst,
  input logic        busy,
  input logic        done_flag,
  input logic        rd_req_valid,
  input logic        rd_req_ready,
  input logic [31:0] rd_req_addr,
  input logic        rd_resp_valid,
  input logic        wr_valid,
  input logic        wr_ready,
  input logic [31:0] wr_addr,
  input logic [7:0]  wr_data,
  input logic        wr_ack
);
  logic [7:0]  unans;
  logic        rd_seen, wr_seen;
  logic [31:0] rd_last, wr_last;
  logic        rd_fire, wr_fire;

  assign rd_fire = rd_req_valid && rd_req_ready;
  assign wr_fire = wr_valid && wr_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      unans <= '0; rd_seen <= 1'b0; wr_seen <= 1'b0; rd_last <= '0; wr_last <= '0;
    end else begin
      unans <= unans + {7'd0, rd_fire} - {7'd0, rd_resp_valid};
      if (!busy) rd_seen <= 1'b0;
      else if (rd_fire) begin rd_seen <= 1'b1; rd_last <= rd_req_addr; end
      if (!busy) wr_seen <= 1'b0;
      else if (wr_fire) begin wr_seen <= 1'b1; wr_last <= wr_addr; end
    end
  end

  AST_READ_CREDIT: assert property (@(posedge clk) disable iff (rst)
    unans <= 8'(DEPTH)); // R8
  AST_RD_ADDR_STEP: assert property (@(posedge clk) disable iff (rst)
    (busy && rd_seen && rd_fire) |-> (rd_req_addr == rd_last + 32'd1)); // R3
  AST_WR_ADDR_STEP: assert property (@(posedge clk) disable iff (rst)
    (busy && wr_seen && wr_fire) |-> (wr_addr == wr_last + 32'd1)); // R7
  AST_WR_HOLD: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr) && $stable(wr_data))); // R9
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (!rd_req_valid && !wr_valid)); // R10
  AST_DONE_AFTER_ACK: assert property (@(posedge clk) disable iff (rst)
    $rose(done_flag) |-> $past(wr_ack)); // R10
endmodule

bind c3f_engine c3f_checker #(.DEPTH(FIFO_DEPTH)) u_c3f_checker (
  .clk(clk), .rst(rst), .busy(busy), .done_flag(done_flag),
  .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready), .rd_req_addr(rd_req_addr),
  .rd_resp_valid(rd_resp_valid), .wr_valid(wr_valid), .wr_ready(wr_ready),
  .wr_addr(wr_addr), .wr_data(wr_data), .wr_ack(wr_ack)
);

// File: tb/test_c3f_engine.sv
module test_c3f_engine;
  localparam int ROWS = 5, COLS = 7, DEPTH = 4, TOTAL = ROWS * COLS;
  localparam int SRC = 'h040, DST = 'h200;

  typedef struct { int addr; int data; string req; } exp_t;

  logic clk = 0, rst = 1;
  logic s_wr_en = 0, s_rd_en = 0;
  logic [7:0] s_wr_addr = 0, s_rd_addr = 0;
  logic [31:0] s_wr_data = 0, s_rd_data;
  logic rd_req_valid, rd_req_ready = 0, rd_resp_valid = 0;
  logic [31:0] rd_req_addr, wr_addr;
  logic [7:0] rd_resp_data = 0, wr_data;
  logic wr_valid, wr_ready = 0, wr_ack = 0;

  int vectors = 0, fails = 0;
  int rd_pct = 100, wr_pct = 100;
  bit resp_hold = 0, ack_hold = 0;
  int rdq[$];
  exp_t expq[$];
  int ack_pend = 0, rd_idx = 0;
  logic [7:0] mem [0:1023];
  bit stall_prev = 0;
  logic [31:0] st_addr; logic [7:0] st_data;

  always #5 clk = ~clk;

  c3f_engine #(.ROWS(ROWS), .COLS(COLS), .FIFO_DEPTH(DEPTH)) i_c3f_engine (
    .clk(clk), .rst(rst), .s_wr_en(s_wr_en), .s_wr_addr(s_wr_addr), .s_wr_data(s_wr_data),
    .s_rd_en(s_rd_en), .s_rd_addr(s_rd_addr), .s_rd_data(s_rd_data),
    .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready), .rd_req_addr(rd_req_addr),
    .rd_resp_valid(rd_resp_valid), .rd_resp_data(rd_resp_data),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
    .wr_ack(wr_ack)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // memory model and scoreboard monitor, all decisions away from the active edge
  always @(negedge clk) begin
    bit r, w;
    r = ($urandom % 100) < rd_pct;
    w = ($urandom % 100) < wr_pct;
    if (rst) begin
      rd_req_ready = 0; rd_resp_valid = 0; wr_ready = 0; wr_ack = 0;
    end else begin
      rd_req_ready = r;
      if (rd_req_valid && r) begin
        chk(rd_req_addr == 32'(SRC + rd_idx), "R3 read address", rd_req_addr, SRC + rd_idx);
        rdq.push_back(int'(rd_req_addr));
        rd_idx++;
      end
      if (!resp_hold && rdq.size() > 0 && ($urandom % 100) < rd_pct) begin
        rd_resp_valid = 1;
        rd_resp_data = mem[rdq.pop_front() % 1024];
      end else rd_resp_valid = 0;
      if (stall_prev)
        chk(wr_valid && wr_addr == st_addr && wr_data == st_data, "R9 stalled write held",
            int'(wr_data), int'(st_data));
      stall_prev = wr_valid && !w;
      st_addr = wr_addr; st_data = wr_data;
      wr_ready = w;
      if (wr_valid && w) begin
        if (expq.size() == 0) chk(0, "R7 unexpected write", int'(wr_addr), -1);
        else begin
          exp_t e;
          e = expq.pop_front();
          chk(int'(wr_addr) == e.addr, "R7 write address", int'(wr_addr), e.addr);
          chk(int'(wr_data) == e.data, e.req, int'(wr_data), e.data);
          mem[wr_addr % 1024] = wr_data;
        end
        ack_pend++;
      end
      if (!ack_hold && ack_pend > 0 && ($urandom % 2) == 0) begin
        wr_ack = 1; ack_pend--;
      end else wr_ack = 0;
    end
  end

  task automatic reg_wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); s_wr_en = 1; s_wr_addr = a; s_wr_data = d;
    @(negedge clk); s_wr_en = 0;
  endtask

  task automatic reg_rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); s_rd_en = 1; s_rd_addr = a;
    @(negedge clk); s_rd_en = 0; d = s_rd_data;
  endtask

  function automatic int px(int r, int c);
    int rr, cc;
    rr = (r < 0) ? 0 : (r >= ROWS) ? ROWS - 1 : r;
    cc = (c < 0) ? 0 : (c >= COLS) ? COLS - 1 : c;
    return int'(mem[SRC + rr * COLS + cc]);
  endfunction

  // driver: fills the source frame and pushes expected writes
  task automatic run_frame(input int pat, input bit hold_r, input bit hold_a);
    logic [31:0] s;
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < COLS; c++)
        case (pat)
          0: mem[SRC + r * COLS + c] = 8'(r * 20 + c * 3);
          1: mem[SRC + r * COLS + c] = 8'($urandom);
          default: mem[SRC + r * COLS + c] = ($urandom % 2) ? 8'hFF : 8'h00;
        endcase
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < COLS; c++) begin
        exp_t e; int sum;
        sum = px(r+1, c-1) + 2 * px(r+1, c) + px(r+1, c+1)
            - px(r-1, c-1) - 2 * px(r-1, c) - px(r-1, c+1);
        e.addr = DST + r * COLS + c;
        e.data = (sum < 0) ? 0 : (sum > 255) ? 255 : sum;
        if (r == 0 || r == ROWS-1 || c == 0 || c == COLS-1) e.req = "R5 border pixel";
        else if (sum < 0 || sum > 255) e.req = "R6 saturated pixel";
        else e.req = "R4 interior pixel";
        expq.push_back(e);
      end
    rd_idx = 0;
    resp_hold = hold_r; ack_hold = hold_a;
    reg_wr(8'h10, SRC);
    reg_wr(8'h18, DST);
    reg_wr(8'h00, 1);
    reg_rd(8'h00, s);
    chk(s[2] == 0, "R10 idle low while running", int'(s[2]), 0);
    if (hold_r) begin
      repeat (40) @(negedge clk);
      chk(rdq.size() == DEPTH, "R8 requests capped at FIFO depth", rdq.size(), DEPTH);
      resp_hold = 0;
    end
    if (hold_a) begin
      while (expq.size() > 0) @(negedge clk);
      repeat (10) @(negedge clk);
      reg_rd(8'h00, s);
      chk(s[1] == 0 && s[2] == 0, "R10 no done before last ack", int'(s[2:1]), 0);
      ack_hold = 0;
    end
    s = 0;
    while (!s[1]) reg_rd(8'h00, s);
    chk(s[2] == 1, "R10 idle after done", int'(s[2]), 1);
    chk(s[0] == 0, "R10 start bit reads zero", int'(s[0]), 0);
    reg_rd(8'h00, s);
    chk(s[1] == 0, "R10 done cleared by read", int'(s[1]), 0);
    chk(expq.size() == 0, "R7 all pixels written", expq.size(), 0);
    chk(rd_idx == TOTAL, "R3 each source pixel read once", rd_idx, TOTAL);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    logic [31:0] s;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(!rd_req_valid && !wr_valid, "R1 no traffic after reset", int'({rd_req_valid, wr_valid}), 0);
    reg_rd(8'h00, s);
    chk(s[2:0] == 3'b100, "R1 status after reset", int'(s[2:0]), 4);
    reg_wr(8'h10, 32'h1234_5678);
    reg_wr(8'h18, 32'h0BAD_F00D);
    reg_rd(8'h10, s);
    chk(s == 32'h1234_5678, "R2 source register", int'(s), 32'h1234_5678);
    reg_rd(8'h18, s);
    chk(s == 32'h0BAD_F00D, "R2 destination register", int'(s), 32'h0BAD_F00D);
    rd_pct = 100; wr_pct = 100;
    run_frame(0, 0, 0);
    rd_pct = 50; wr_pct = 40;
    run_frame(1, 0, 0);
    rd_pct = 70; wr_pct = 60;
    run_frame(2, 1, 0);
    run_frame(1, 0, 1);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule